// File: doc/BRIEF.md
# Serial EEPROM Write Receiver

This block is the write side of a two-wire serial memory target for a 256-byte array. It oversamples the clock and data lines with the system clock. It finds start and stop conditions, shifts bytes in most significant bit first and answers each byte it accepts. It answers by enabling an open-drain pull-down on the data line during the ninth clock.

A transaction opens with a control byte. The control byte must carry device code `1010` in its top four bits and a 0 in bit 0, which marks a write. Bits 3:1 are don't-care bank bits. The next byte loads the address pointer. Every byte after that goes to a downstream page buffer as one address/data strobe. The pointer steps through the low three bits only, so writes wrap inside an 8-byte page.

A stop condition that ends a transaction holding at least one data byte raises a commit pulse, which tells the buffer to start its internal write. While the buffer reports busy, the block acknowledges nothing.

Top module: `eeprom_wr_front`

## Requirements
- R1: A start condition is SDA falling while SCL is high, and only a start condition begins a control byte. Bytes clocked in while idle are not acknowledged.
- R2: A control byte is acknowledged exactly when bits 7:4 equal `1010` and bit 0 is 0. Bits 3:1 have no effect.
- R3: `sda_oe_o` is 1 only from the SCL fall after the eighth bit to the SCL fall after the ninth clock, and only for an accepted byte. Outside that window it is 0.
- R4: The byte after an accepted control byte is acknowledged and loaded into the address pointer.
- R5: Every later byte is acknowledged and produces a one-cycle `wr_valid_o` strobe. The strobe carries the byte on `wr_data_o` and the current pointer on `wr_addr_o`.
- R6: After each data byte the pointer adds 1 to bits 2:0 modulo 8, and bits 7:3 stay fixed. A ninth or later byte therefore revisits earlier addresses of the same page.
- R7: A stop condition (SDA rising while SCL is high) after at least one data byte gives exactly one one-cycle `commit_o` pulse.
- R8: While `busy_i` is 1 no byte is acknowledged and no strobe is issued. This includes a control byte that matches.
- R9: After a control byte that is rejected, no byte is acknowledged until the next start condition.
- R10: A repeated start or a stop that arrives before any data byte ends the transaction without a commit. A repeated start begins a new control byte.
- R11: After reset `sda_oe_o`, `wr_valid_o` and `commit_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level as seen on the wire |
| busy_i | input | 1 | Downstream internal write cycle in progress |
| sda_oe_o | output | 1 | Open-drain pull-down enable for the acknowledge |
| wr_valid_o | output | 1 | One-cycle strobe for a received data byte |
| wr_addr_o | output | 8 | Array address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| commit_o | output | 1 | One-cycle pulse that starts the internal write |

## Verification
The transaction table covers several control bytes against the acknowledge decision: the plain code, the code with bank bits set, the read bit set, a wrong device code and a matching code while busy. Together these separate the code compare, the direction check and the busy gate. Data lengths of 1, 5, 8 and 10 bytes are used, with start addresses chosen so the pointer wraps at the page edge. This distinguishes a pointer that wraps in the low bits from one that carries into bits 7:3. Directed cases cover the commit rules: a stop right after the control byte, a stop right after the address, and a repeated start after the address. They also cover a byte clocked in with no start condition, which must get no answer.

// File: rtl/eeprom_wr_pkg.sv
package eeprom_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_DATA,
    ST_SKIP
  } fe_state_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/bus_cond_detect.sv
module bus_cond_detect (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  // data edges while the clock is held high are bus conditions
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/byte_shifter.sv
module byte_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         scl_rise_i,
  input  logic         scl_fall_i,
  input  logic         sda_i,
  output logic [W-1:0] byte_o,
  output logic         byte_done_o,
  output logic         ack_end_o
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic          ack_phase_q;

  assign byte_done_o = scl_fall_i & ~clear_i & ~ack_phase_q & (cnt_q == CW'(W));
  assign ack_end_o   = scl_fall_i & ~clear_i & ack_phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q       <= '0;
      ack_phase_q <= 1'b0;
      byte_o      <= '0;
    end else if (clear_i) begin
      cnt_q       <= '0;
      ack_phase_q <= 1'b0;
    end else begin
      if (scl_rise_i && cnt_q < CW'(W)) begin
        byte_o <= {byte_o[W-2:0], sda_i};
        cnt_q  <= cnt_q + 1'b1;
      end
      if (byte_done_o) ack_phase_q <= 1'b1;
      if (ack_end_o) begin
        ack_phase_q <= 1'b0;
        cnt_q       <= '0;
      end
    end
  end
endmodule

// File: rtl/addr_ptr.sv
module addr_ptr #(
  parameter int AW = 8,
  parameter int PB = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= {ptr_o[AW-1:PB], ptr_o[PB-1:0] + 1'b1};  // wrap inside page
  end
endmodule

// File: rtl/eeprom_wr_front.sv
module eeprom_wr_front
  import eeprom_wr_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              busy_i,
  output logic              sda_oe_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o
);
  localparam int PAGE_BITS = $clog2(PAGE_BYTES);

  logic start, stop, scl_rise, scl_fall;
  logic [DATA_W-1:0] rx_byte;
  logic byte_done, ack_end;
  logic [ADDR_W-1:0] ptr;
  fe_state_e state_q;
  logic got_data_q;
  logic ctrl_ok, accept, load_ptr, take_data;

  bus_cond_detect u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .start_o(start), .stop_o(stop), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall)
  );

  byte_shifter #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clear_i(start | stop),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i,
    .byte_o(rx_byte), .byte_done_o(byte_done), .ack_end_o(ack_end)
  );

  assign ctrl_ok   = (rx_byte[DATA_W-1 -: 4] == DEV_CODE) && !rx_byte[0];
  assign accept    = byte_done && !busy_i &&
                     ((state_q == ST_CTRL && ctrl_ok) || state_q == ST_ADDR || state_q == ST_DATA);
  assign load_ptr  = accept && state_q == ST_ADDR;
  assign take_data = accept && state_q == ST_DATA;

  addr_ptr #(.AW(ADDR_W), .PB(PAGE_BITS)) u_ptr (
    .clk_i, .rst_ni, .load_i(load_ptr), .load_val_i(rx_byte[ADDR_W-1:0]),
    .inc_i(take_data), .ptr_o(ptr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      got_data_q <= 1'b0;
      sda_oe_o   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      commit_o   <= 1'b0;
    end else begin
      wr_valid_o <= take_data;
      commit_o   <= stop && state_q == ST_DATA && got_data_q;
      if (take_data) begin
        wr_addr_o <= ptr;
        wr_data_o <= rx_byte;
      end
      if (start || stop || ack_end) sda_oe_o <= 1'b0;
      else if (accept)              sda_oe_o <= 1'b1;

      if (start) begin
        state_q    <= ST_CTRL;
        got_data_q <= 1'b0;
      end else if (stop) begin
        state_q    <= ST_IDLE;
        got_data_q <= 1'b0;
      end else if (byte_done) begin
        case (state_q)
          ST_CTRL: state_q <= accept ? ST_ADDR : ST_SKIP;
          ST_ADDR: state_q <= accept ? ST_DATA : ST_SKIP;
          ST_DATA: begin
            if (accept) got_data_q <= 1'b1;
            else        state_q    <= ST_SKIP;
          end
          default: state_q <= state_q;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_wr_front_chk.sv
module eeprom_wr_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic busy_i,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic commit_o
);
  p_ack_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);
  p_no_ack_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(busy_i));
  p_no_fwd_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(busy_i));
  p_fwd_with_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> sda_oe_o);
  p_valid_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);
  p_commit_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> !commit_o);
  p_commit_no_ack_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> !sda_oe_o);
endmodule

bind eeprom_wr_front eeprom_wr_front_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .busy_i(busy_i),
  .sda_oe_o(sda_oe_o), .wr_valid_o(wr_valid_o), .commit_o(commit_o)
);

// File: tb/eeprom_wr_front_bench.sv
module eeprom_wr_front_bench;
  localparam int HALF = 4;

  typedef struct packed {
    logic [7:0] ctrl;
    logic [7:0] addr;
    logic [4:0] ndata;
    logic [7:0] dbase;
    logic       busy;
    logic       ack;
  } vec_t;

  // ctrl, addr, ndata, data base, busy, expect control ack
  localparam vec_t VECS [8] = '{
    '{8'hA0, 8'h10, 5'd1,  8'h5A, 1'b0, 1'b1},  // R2 R4 R5 R7 single byte
    '{8'hAE, 8'h3D, 5'd5,  8'h80, 1'b0, 1'b1},  // R2 bank bits ignored, R6 wrap
    '{8'hA2, 8'hF8, 5'd8,  8'h11, 1'b0, 1'b1},  // R6 full page
    '{8'hA0, 8'h41, 5'd10, 8'hC0, 1'b0, 1'b1},  // R6 overrun revisits page
    '{8'hA1, 8'h20, 5'd2,  8'h01, 1'b0, 1'b0},  // R2 read bit rejected, R9
    '{8'hB0, 8'h20, 5'd2,  8'h01, 1'b0, 1'b0},  // R2 wrong code, R9
    '{8'hA0, 8'h30, 5'd2,  8'h01, 1'b1, 1'b0},  // R8 busy
    '{8'h2A, 8'h30, 5'd1,  8'h01, 1'b0, 1'b0}   // R9 code in wrong nibble
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, busy = 1'b0;
  logic sda_line, sda_oe, wr_valid, commit;
  logic [7:0] wr_addr, wr_data;
  int n_vec = 0, n_fail = 0;
  int wr_cnt = 0, commit_cnt = 0;
  logic [7:0] log_a [64];
  logic [7:0] log_d [64];
  bit done = 0;

  always #4 clk = ~clk;
  assign sda_line = sda_drv & ~sda_oe;

  eeprom_wr_front u_eeprom_wr_front (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_line), .busy_i(busy),
    .sda_oe_o(sda_oe), .wr_valid_o(wr_valid), .wr_addr_o(wr_addr),
    .wr_data_o(wr_data), .commit_o(commit)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      log_a[wr_cnt % 64] <= wr_addr;
      log_d[wr_cnt % 64] <= wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (commit) commit_cnt <= commit_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half_wait();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; half_wait();
    scl = 1'b1;     half_wait();
    sda_drv = 1'b0; half_wait();
    scl = 1'b0;     half_wait();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; half_wait();
    scl = 1'b1;     half_wait();
    sda_drv = 1'b1; half_wait();
    half_wait();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; half_wait();
      scl = 1'b1;     half_wait();
      if (i == 3) check(sda_oe == 1'b0, "R3 released in data bit", sda_oe, 0);
      scl = 1'b0;
    end
    sda_drv = 1'b1; half_wait();
    scl = 1'b1;
    repeat (2) @(negedge clk);
    ack = (sda_oe == 1'b1) && (sda_line == 1'b0);
    repeat (2) @(negedge clk);
    scl = 1'b0; half_wait();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    logic ack;
    int w0, c0;
    repeat (3) @(negedge clk);
    check(sda_oe == 0 && wr_valid == 0 && commit == 0, "R11 reset outputs",
          {sda_oe, wr_valid, commit}, 0);
    rst_n = 1'b1;
    half_wait();

    // table walk
    for (int v = 0; v < 8; v++) begin
      vec_t t;
      t = VECS[v];
      busy = t.busy;
      w0 = wr_cnt; c0 = commit_cnt;
      bus_start();
      send_byte(t.ctrl, ack);
      check(ack == t.ack, "R2 R8 control ack", ack, t.ack);
      send_byte(t.addr, ack);
      check(ack == t.ack, "R4 R9 address ack", ack, t.ack);
      for (int i = 0; i < int'(t.ndata); i++) begin
        send_byte(t.dbase + 8'(i), ack);
        check(ack == t.ack, "R5 R9 data ack", ack, t.ack);
      end
      bus_stop();
      busy = 1'b0;
      if (t.ack) begin
        check(wr_cnt - w0 == int'(t.ndata), "R5 strobe count", wr_cnt - w0, t.ndata);
        for (int i = 0; i < int'(t.ndata); i++) begin
          logic [7:0] ea;
          ea = {t.addr[7:3], t.addr[2:0] + 3'(i)};
          check(log_a[(w0 + i) % 64] == ea, "R6 strobe address", log_a[(w0 + i) % 64], ea);
          check(log_d[(w0 + i) % 64] == t.dbase + 8'(i), "R5 strobe data",
                log_d[(w0 + i) % 64], t.dbase + 8'(i));
        end
        check(commit_cnt - c0 == 1, "R7 single commit", commit_cnt - c0, 1);
      end else begin
        check(wr_cnt == w0, "R8 R9 no strobe", wr_cnt - w0, 0);
        check(commit_cnt == c0, "R8 R9 no commit", commit_cnt - c0, 0);
      end
    end

    // R1: byte with no start condition gets no answer
    w0 = wr_cnt;
    send_byte(8'hA0, ack);
    check(ack == 0, "R1 idle byte ignored", ack, 0);
    bus_stop();

    // R10: stop after control byte only
    c0 = commit_cnt;
    bus_start();
    send_byte(8'hA0, ack);
    check(ack == 1, "R2 control ack", ack, 1);
    bus_stop();
    check(commit_cnt == c0, "R10 stop after control", commit_cnt - c0, 0);

    // R10: stop after address only
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h77, ack);
    check(ack == 1, "R4 address ack", ack, 1);
    bus_stop();
    check(commit_cnt == c0, "R10 stop after address", commit_cnt - c0, 0);

    // R10: repeated start after address, then a fresh write
    bus_start();
    send_byte(8'hA0, ack);
    send_byte(8'h66, ack);
    bus_start();
    check(commit_cnt == c0, "R10 repeated start no commit", commit_cnt - c0, 0);
    send_byte(8'hA4, ack);
    check(ack == 1, "R10 new control after repeated start", ack, 1);
    send_byte(8'h50, ack);
    send_byte(8'h3C, ack);
    bus_stop();
    check(wr_cnt - w0 == 1 && log_a[w0 % 64] == 8'h50, "R10 new write address",
          log_a[w0 % 64], 8'h50);
    check(log_d[w0 % 64] == 8'h3C, "R5 new write data", log_d[w0 % 64], 8'h3C);
    check(commit_cnt - c0 == 1, "R7 commit after new write", commit_cnt - c0, 1);

    // R8: busy rises mid-transaction stops answering
    bus_start();
    send_byte(8'hA0, ack);
    busy = 1'b1;
    send_byte(8'h08, ack);
    check(ack == 0, "R8 address not acked while busy", ack, 0);
    busy = 1'b0;
    send_byte(8'h99, ack);
    check(ack == 0, "R9 silent until next start", ack, 0);
    bus_stop();
    check(commit_cnt - c0 == 1, "R8 no commit while busy", commit_cnt - c0, 1);
    check(sda_oe == 0, "R3 released at rest", sda_oe, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule